// File: doc/BRIEF.md
# Page-splitting flash program sequencer

This block turns high-level flash requests into the exact series of low-level operations a serial NOR flash expects. A request carries an operation, a start address and, for writes, a byte length. Write data arrives on a separate byte stream. The block cuts a write into program operations that each stay inside one flash page. Before every program operation it sends a write-enable command and has a polling engine confirm that the write-enable latch is set. After the data it has the polling engine wait until the device reports it is no longer busy.

Subsector erase and whole-chip erase requests go through the same steps: enable, confirm the latch, issue the command, then poll for completion with a timeout suited to that operation. A serial protocol engine and a status polling engine sit behind two command ports. The block hands them one sub-command at a time and waits for each to report done or error. Any reported error ends the request at once, and the block flags it on the completion pulse.

Top module: `flash_prog_seq`

## Requirements
- R1: The first program operation of a write covers min(256 - (start address mod 256), length) bytes. No program operation (`cmd_opcode` 0x32) ever spans a 256-byte page boundary.
- R2: Each later program operation starts where the previous one ended. It covers a full 256-byte page, or the bytes that remain if fewer than 256 are left. The byte counts add up to the requested length.
- R3: Every program or erase command is preceded by two steps in this order. First, a write-enable command: `cmd_opcode` 0x06, address and data lane modes both 0 (none). Second, a poll with `poll_mask` 0x02, `poll_match` 0x02 and `poll_timeout` 5000.
- R4: A program command sends opcode 0x32 with the chunk address on four lanes (mode 2) and data on four lanes (mode 2). `cmd_nbytes` equals the chunk length. There are no dummy cycles.
- R5: After each program or erase command, the block issues a busy poll with `poll_mask` 0x01 and `poll_match` 0x00. The timeout is 5000 for program, 400000 for subsector erase and 100000000 for chip erase. The next step is taken only after `poll_done`.
- R6: A subsector erase (`req_op` 1) sends opcode 0x20 with a one-lane address (mode 1), aligned down to a 4096-byte boundary. It has no data (mode 0) and `cmd_nbytes` 0.
- R7: A chip erase (`req_op` 2) sends opcode 0xC7 with no address (mode 0) and no data (mode 0).
- R8: A `cmd_err` or `poll_err` ends the request. `done` is raised with `err` = 1, and no further command or poll is issued.
- R9: A write (`req_op` 0) with length 0 raises `done` with `err` = 0 in the cycle right after acceptance. No command or poll is issued.
- R10: `req_op` 3 is reserved. It is answered with `done` and `err` = 1 in the cycle right after acceptance. No command or poll is issued.
- R11: At most one sub-command is outstanding at a time. `cmd_valid` and `poll_valid` are never high together. A pending `cmd_valid` holds its fields until `cmd_ready`.
- R12: Write bytes pass from `din_*` to `tx_*` only while a program command is outstanding. Each program command passes exactly `cmd_nbytes` bytes, unchanged.
- R13: `req_ready` is high only when idle. `done` is a one-cycle pulse. After reset the block is idle, with no command, poll or data request active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on this cycle |
| req_op | input | 2 | 0 write, 1 subsector erase, 2 chip erase, 3 reserved |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Write length in bytes |
| din_valid | input | 1 | Write byte offered |
| din_data | input | 8 | Write byte |
| din_ready | output | 1 | Write byte taken |
| cmd_valid | output | 1 | Sub-command to protocol engine |
| cmd_ready | input | 1 | Protocol engine accepts sub-command |
| cmd_opcode | output | 8 | Instruction byte (one lane) |
| cmd_addr_mode | output | 2 | Address lanes: 0 none, 1 one, 2 four |
| cmd_addr | output | ADDR_W | 24-bit command address |
| cmd_data_mode | output | 2 | Data lanes: 0 none, 1 one, 2 four |
| cmd_nbytes | output | LEN_W | Data bytes in this command |
| cmd_done | input | 1 | Sub-command finished |
| cmd_err | input | 1 | Sub-command failed |
| tx_valid | output | 1 | Write byte to protocol engine |
| tx_data | output | 8 | Write byte |
| tx_ready | input | 1 | Protocol engine takes byte |
| poll_valid | output | 1 | Poll request to polling engine |
| poll_ready | input | 1 | Polling engine accepts request |
| poll_mask | output | 8 | Status bits compared |
| poll_match | output | 8 | Value the masked status must reach |
| poll_timeout | output | TMO_W | Poll limit in cycles |
| poll_done | input | 1 | Status matched |
| poll_err | input | 1 | Poll timed out or failed |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request failed, valid with done |

## Verification
Several properties are checked on every cycle. No program command crosses a page. Program commands always use four address lanes and four data lanes. Erase addresses are subsector aligned. Command and poll requests never overlap, and a pending command holds steady. Write bytes move only while a program command is outstanding. `done` is a single-cycle pulse that carries `err`.

Other behaviour needs whole request sequences, so only the bench scenarios can show it. This covers the exact order of write-enable, latch poll, operation and busy poll, and the chunk lengths and addresses across a write. It also covers the per-operation timeouts, the immediate finish of empty and reserved requests, and the stop after an injected error part-way through a write.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      LANES_NONE = 2'd0,
      LANES_ONE  = 2'd1,
      LANES_QUAD = 2'd2
   } lanes_e;

   typedef enum logic [1:0] {
      OP_PROGRAM   = 2'd0,
      OP_ERASE_SUB = 2'd1,
      OP_ERASE_ALL = 2'd2,
      OP_RSVD      = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WE_ISSUE,
      S_WE_WAIT,
      S_WEL_ISSUE,
      S_WEL_WAIT,
      S_OP_ISSUE,
      S_OP_WAIT,
      S_BSY_ISSUE,
      S_BSY_WAIT,
      S_FINISH
   } step_e;

endpackage

// File: rtl/flash_seq_chunk.sv
// Length of the next program operation: room left in the current page,
// clamped to the bytes still to be written.
module flash_seq_chunk #(
   parameter int LEN_W      = 16,
   parameter int PAGE_BYTES = 256,
   localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
   input  logic [PAGE_W-1:0] page_off,
   input  logic [LEN_W-1:0]  remain,
   output logic [LEN_W-1:0]  chunk
);
   logic [PAGE_W:0] room;

   always_comb begin
      room  = (PAGE_W+1)'(PAGE_BYTES) - {1'b0, page_off};
      chunk = (remain < LEN_W'(room)) ? remain : LEN_W'(room);
   end
endmodule

// File: rtl/flash_seq_gate.sv
// Lets exactly 'limit' bytes through while open; counter clears per chunk.
module flash_seq_gate #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             open,
   input  logic [LEN_W-1:0] limit,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   input  logic             out_ready
);
   logic [LEN_W-1:0] sent;
   logic             pass;

   assign pass      = open && (sent < limit);
   assign out_valid = in_valid && pass;
   assign in_ready  = out_ready && pass;
   assign out_data  = in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sent <= '0;
      else if (clear)
         sent <= '0;
      else if (in_valid && out_ready && pass)
         sent <= sent + 1'b1;
   end
endmodule

// File: rtl/flash_seq_fmt.sv
// Field formatter for the two engine ports, driven by the current step.
module flash_seq_fmt
   import flash_seq_pkg::*;
#(
   parameter int          ADDR_W    = 24,
   parameter int          LEN_W     = 16,
   parameter int          SUB_BYTES = 4096,
   parameter int          TMO_W     = 32,
   parameter logic [7:0]  OPC_WREN  = 8'h06,
   parameter logic [7:0]  OPC_PROG  = 8'h32,
   parameter logic [7:0]  OPC_SUB   = 8'h20,
   parameter logic [7:0]  OPC_CHIP  = 8'hC7,
   parameter int          WEL_BIT   = 1,
   parameter int          WIP_BIT   = 0,
   parameter logic [TMO_W-1:0] TMO_PROG = 32'd5000,
   parameter logic [TMO_W-1:0] TMO_SUB  = 32'd400000,
   parameter logic [TMO_W-1:0] TMO_CHIP = 32'd100000000
) (
   input  step_e             step,
   input  op_e               op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  chunk,
   output logic [7:0]        cmd_opcode,
   output logic [1:0]        cmd_addr_mode,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [1:0]        cmd_data_mode,
   output logic [LEN_W-1:0]  cmd_nbytes,
   output logic [7:0]        poll_mask,
   output logic [7:0]        poll_match,
   output logic [TMO_W-1:0]  poll_timeout
);
   localparam logic [7:0]        WEL_M    = 8'(1 << WEL_BIT);
   localparam logic [7:0]        WIP_M    = 8'(1 << WIP_BIT);
   localparam logic [ADDR_W-1:0] SUB_MASK = ~ADDR_W'(SUB_BYTES - 1);

   always_comb begin
      cmd_opcode    = OPC_WREN;
      cmd_addr_mode = LANES_NONE;
      cmd_addr      = '0;
      cmd_data_mode = LANES_NONE;
      cmd_nbytes    = '0;
      if (step == S_OP_ISSUE) begin
         case (op)
            OP_PROGRAM: begin
               cmd_opcode    = OPC_PROG;
               cmd_addr_mode = LANES_QUAD;
               cmd_addr      = addr;
               cmd_data_mode = LANES_QUAD;
               cmd_nbytes    = chunk;
            end
            OP_ERASE_SUB: begin
               cmd_opcode    = OPC_SUB;
               cmd_addr_mode = LANES_ONE;
               cmd_addr      = addr & SUB_MASK;
            end
            default: cmd_opcode = OPC_CHIP;
         endcase
      end
   end

   always_comb begin
      if (step == S_WEL_ISSUE) begin
         poll_mask    = WEL_M;
         poll_match   = WEL_M;
         poll_timeout = TMO_PROG;
      end else begin
         poll_mask  = WIP_M;
         poll_match = 8'h00;
         case (op)
            OP_ERASE_SUB: poll_timeout = TMO_SUB;
            OP_ERASE_ALL: poll_timeout = TMO_CHIP;
            default:      poll_timeout = TMO_PROG;
         endcase
      end
   end
endmodule

// File: rtl/flash_seq_ctrl.sv
// Step sequencer: enable, latch poll, operation, busy poll, per chunk.
module flash_seq_ctrl
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [LEN_W-1:0]  chunk,
   input  logic              cmd_ready,
   input  logic              cmd_done,
   input  logic              cmd_err,
   input  logic              poll_ready,
   input  logic              poll_done,
   input  logic              poll_err,
   output step_e             step,
   output op_e               op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LEN_W-1:0]  remain_q,
   output logic              req_ready,
   output logic              cmd_valid,
   output logic              poll_valid,
   output logic              done,
   output logic              err
);
   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step     <= S_IDLE;
         op_q     <= OP_PROGRAM;
         addr_q   <= '0;
         remain_q <= '0;
         err_q    <= 1'b0;
      end else begin
         case (step)
            S_IDLE: if (req_valid) begin
               op_q     <= op_e'(req_op);
               addr_q   <= req_addr;
               remain_q <= req_len;
               err_q    <= 1'b0;
               if (op_e'(req_op) == OP_RSVD) begin
                  err_q <= 1'b1;
                  step  <= S_FINISH;
               end else if (op_e'(req_op) == OP_PROGRAM && req_len == '0)
                  step <= S_FINISH;
               else
                  step <= S_WE_ISSUE;
            end
            S_WE_ISSUE:  if (cmd_ready) step <= S_WE_WAIT;
            S_WE_WAIT: begin
               if (cmd_err) begin
                  err_q <= 1'b1;
                  step  <= S_FINISH;
               end else if (cmd_done)
                  step <= S_WEL_ISSUE;
            end
            S_WEL_ISSUE: if (poll_ready) step <= S_WEL_WAIT;
            S_WEL_WAIT: begin
               if (poll_err) begin
                  err_q <= 1'b1;
                  step  <= S_FINISH;
               end else if (poll_done)
                  step <= S_OP_ISSUE;
            end
            S_OP_ISSUE:  if (cmd_ready) step <= S_OP_WAIT;
            S_OP_WAIT: begin
               if (cmd_err) begin
                  err_q <= 1'b1;
                  step  <= S_FINISH;
               end else if (cmd_done)
                  step <= S_BSY_ISSUE;
            end
            S_BSY_ISSUE: if (poll_ready) step <= S_BSY_WAIT;
            S_BSY_WAIT: begin
               if (poll_err) begin
                  err_q <= 1'b1;
                  step  <= S_FINISH;
               end else if (poll_done) begin
                  if (op_q == OP_PROGRAM) begin
                     addr_q   <= addr_q + ADDR_W'(chunk);
                     remain_q <= remain_q - chunk;
                     step     <= (remain_q == chunk) ? S_FINISH : S_WE_ISSUE;
                  end else
                     step <= S_FINISH;
               end
            end
            default: step <= S_IDLE;
         endcase
      end
   end

   assign req_ready  = (step == S_IDLE);
   assign cmd_valid  = (step == S_WE_ISSUE) || (step == S_OP_ISSUE);
   assign poll_valid = (step == S_WEL_ISSUE) || (step == S_BSY_ISSUE);
   assign done       = (step == S_FINISH);
   assign err        = (step == S_FINISH) && err_q;
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import flash_seq_pkg::*;
#(
   parameter int          ADDR_W     = 24,
   parameter int          LEN_W      = 16,
   parameter int          PAGE_BYTES = 256,
   parameter int          SUB_BYTES  = 4096,
   parameter int          TMO_W      = 32,
   parameter logic [7:0]  OPC_WREN   = 8'h06,
   parameter logic [7:0]  OPC_PROG   = 8'h32,
   parameter logic [7:0]  OPC_SUB    = 8'h20,
   parameter logic [7:0]  OPC_CHIP   = 8'hC7,
   parameter int          WEL_BIT    = 1,
   parameter int          WIP_BIT    = 0,
   parameter logic [TMO_W-1:0] TMO_PROG = 32'd5000,
   parameter logic [TMO_W-1:0] TMO_SUB  = 32'd400000,
   parameter logic [TMO_W-1:0] TMO_CHIP = 32'd100000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              din_valid,
   input  logic [7:0]        din_data,
   output logic              din_ready,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [7:0]        cmd_opcode,
   output logic [1:0]        cmd_addr_mode,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [1:0]        cmd_data_mode,
   output logic [LEN_W-1:0]  cmd_nbytes,
   input  logic              cmd_done,
   input  logic              cmd_err,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   output logic              poll_valid,
   input  logic              poll_ready,
   output logic [7:0]        poll_mask,
   output logic [7:0]        poll_match,
   output logic [TMO_W-1:0]  poll_timeout,
   input  logic              poll_done,
   input  logic              poll_err,
   output logic              done,
   output logic              err
);
   localparam int PAGE_W = $clog2(PAGE_BYTES);
   localparam int SUB_W  = $clog2(SUB_BYTES);

   generate
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if ((SUB_BYTES & (SUB_BYTES - 1)) != 0 || SUB_BYTES < PAGE_BYTES) begin : g_bad_sub
         $error("SUB_BYTES must be a power of two no smaller than a page");
      end
      if (LEN_W <= PAGE_W) begin : g_bad_len
         $error("LEN_W must hold a full page count");
      end
      if (ADDR_W < SUB_W) begin : g_bad_addr
         $error("ADDR_W must cover a subsector");
      end
   endgenerate

   step_e             step;
   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  remain_q;
   logic [LEN_W-1:0]  chunk;

   flash_seq_chunk #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
      .page_off (addr_q[PAGE_W-1:0]),
      .remain   (remain_q),
      .chunk    (chunk)
   );

   flash_seq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
      .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_len,
      .chunk, .cmd_ready, .cmd_done, .cmd_err,
      .poll_ready, .poll_done, .poll_err,
      .step, .op_q, .addr_q, .remain_q,
      .req_ready, .cmd_valid, .poll_valid, .done, .err
   );

   flash_seq_fmt #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SUB_BYTES(SUB_BYTES), .TMO_W(TMO_W),
      .OPC_WREN(OPC_WREN), .OPC_PROG(OPC_PROG), .OPC_SUB(OPC_SUB), .OPC_CHIP(OPC_CHIP),
      .WEL_BIT(WEL_BIT), .WIP_BIT(WIP_BIT),
      .TMO_PROG(TMO_PROG), .TMO_SUB(TMO_SUB), .TMO_CHIP(TMO_CHIP)
   ) u_fmt (
      .step, .op(op_q), .addr(addr_q), .chunk,
      .cmd_opcode, .cmd_addr_mode, .cmd_addr, .cmd_data_mode, .cmd_nbytes,
      .poll_mask, .poll_match, .poll_timeout
   );

   flash_seq_gate #(.LEN_W(LEN_W)) u_gate (
      .clk, .rst_n,
      .clear     (step == S_OP_ISSUE),
      .open      ((step == S_OP_WAIT) && (op_q == OP_PROGRAM)),
      .limit     (chunk),
      .in_valid  (din_valid),
      .in_data   (din_data),
      .in_ready  (din_ready),
      .out_valid (tx_valid),
      .out_data  (tx_data),
      .out_ready (tx_ready)
   );
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
   parameter int         ADDR_W     = 24,
   parameter int         LEN_W      = 16,
   parameter int         PAGE_BYTES = 256,
   parameter int         SUB_BYTES  = 4096,
   parameter logic [7:0] OPC_PROG   = 8'h32,
   parameter logic [7:0] OPC_SUB    = 8'h20,
   parameter int         WEL_BIT    = 1,
   localparam int        PAGE_W     = $clog2(PAGE_BYTES),
   localparam int        SUB_W      = $clog2(SUB_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [7:0]        cmd_opcode,
   input logic [1:0]        cmd_addr_mode,
   input logic [SUB_W-1:0]  cmd_addr_lo,
   input logic [1:0]        cmd_data_mode,
   input logic [LEN_W-1:0]  cmd_nbytes,
   input logic              tx_valid,
   input logic              poll_valid,
   input logic [7:0]        poll_mask,
   input logic [7:0]        poll_match,
   input logic              done,
   input logic              err
);
   localparam logic [7:0] WEL_M = 8'(1 << WEL_BIT);
   logic [LEN_W:0] span;
   assign span = (LEN_W+1)'(cmd_nbytes) + (LEN_W+1)'(cmd_addr_lo[PAGE_W-1:0]);

   a_r1_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_opcode == OPC_PROG |-> cmd_nbytes != '0 && span <= (LEN_W+1)'(PAGE_BYTES));
   a_r4_prog_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_opcode == OPC_PROG |-> cmd_addr_mode == 2'd2 && cmd_data_mode == 2'd2);
   a_r6_sub_align: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_opcode == OPC_SUB |-> cmd_addr_lo == '0 && cmd_addr_mode == 2'd1 && cmd_data_mode == 2'd0);
   a_r3_wel_poll: assert property (@(posedge clk) disable iff (!rst_n)
      poll_valid && poll_mask == WEL_M |-> poll_match == WEL_M);
   a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && poll_valid));
   a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) && $stable(cmd_nbytes));
   a_r12_tx_window: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !cmd_valid && !poll_valid && !req_ready && !done);
   a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cmd_valid && !poll_valid);
   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .SUB_BYTES(SUB_BYTES),
   .OPC_PROG(OPC_PROG), .OPC_SUB(OPC_SUB), .WEL_BIT(WEL_BIT)
) u_chk (
   .clk, .rst_n, .req_ready, .cmd_valid, .cmd_ready, .cmd_opcode, .cmd_addr_mode,
   .cmd_addr_lo(cmd_addr[SUB_W-1:0]), .cmd_data_mode, .cmd_nbytes,
   .tx_valid, .poll_valid, .poll_mask, .poll_match, .done, .err
);

// File: tb/test_flash_prog_seq.sv
`timescale 1ns/1ps
module test_flash_prog_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic        din_valid = 1'b1;
   logic [7:0]  din_data = 8'h5A;
   logic        din_ready;
   logic        cmd_valid;
   logic        cmd_ready = 1'b1;
   logic [7:0]  cmd_opcode;
   logic [1:0]  cmd_addr_mode;
   logic [23:0] cmd_addr;
   logic [1:0]  cmd_data_mode;
   logic [15:0] cmd_nbytes;
   logic        cmd_done = 1'b0;
   logic        cmd_err = 1'b0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b1;
   logic        poll_valid;
   logic        poll_ready = 1'b1;
   logic [7:0]  poll_mask;
   logic [7:0]  poll_match;
   logic [31:0] poll_timeout;
   logic        poll_done = 1'b0;
   logic        poll_err = 1'b0;
   logic        done;
   logic        err;

   always #10 clk = ~clk;

   flash_prog_seq i_flash_prog_seq (.*);

   int n_chk = 0, n_fail = 0;
   int ev_kind[64], ev_opc[64], ev_am[64], ev_addr[64], ev_dm[64], ev_nb[64];
   int ev_mask[64], ev_match[64], ev_bytes[64];
   longint ev_tmo[64];
   int n_ev = 0, inj_err_ev = -1;
   int tot_bytes = 0, bad_data = 0, overlap = 0;
   int idx, cnt;
   logic got_err;
   int got_wait;

   task automatic chk(input string rq, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // engine models: accept, consume data, answer done or injected error
   initial begin
      @(negedge clk);
      forever begin
         if (cmd_valid) begin
            idx = n_ev;
            ev_kind[idx] = 0; ev_opc[idx] = cmd_opcode; ev_am[idx] = cmd_addr_mode;
            ev_addr[idx] = cmd_addr; ev_dm[idx] = cmd_data_mode; ev_nb[idx] = cmd_nbytes;
            n_ev++;
            @(posedge clk);
            cnt = 0;
            if (ev_opc[idx] == 8'h32)
               for (int k = 0; k < 2000 && cnt < ev_nb[idx]; k++) begin
                  @(negedge clk);
                  if (tx_valid && tx_ready) cnt++;
               end
            ev_bytes[idx] = cnt;
            @(negedge clk);
            if (idx == inj_err_ev) cmd_err = 1'b1; else cmd_done = 1'b1;
            @(negedge clk);
            cmd_err = 1'b0; cmd_done = 1'b0;
         end else if (poll_valid) begin
            idx = n_ev;
            ev_kind[idx] = 1; ev_mask[idx] = poll_mask; ev_match[idx] = poll_match;
            ev_tmo[idx] = poll_timeout;
            n_ev++;
            @(posedge clk);
            @(negedge clk);
            @(negedge clk);
            if (idx == inj_err_ev) poll_err = 1'b1; else poll_done = 1'b1;
            @(negedge clk);
            poll_err = 1'b0; poll_done = 1'b0;
         end else
            @(negedge clk);
      end
   end

   initial forever begin
      @(negedge clk);
      if (tx_valid && tx_ready) begin
         tot_bytes++;
         if (tx_data !== din_data) bad_data++;
      end
      if (cmd_valid && poll_valid) overlap++;
   end

   task automatic run_req(input logic [1:0] op, input logic [23:0] a, input logic [15:0] len);
      n_ev = 0;
      @(negedge clk);
      chk("R13", "req_ready before request", req_ready, 1);
      req_valid = 1'b1; req_op = op; req_addr = a; req_len = len;
      @(negedge clk);
      req_valid = 1'b0;
      got_wait = 0;
      while (!done && got_wait < 20000) begin
         @(negedge clk);
         got_wait++;
      end
      chk("R13", "done seen", done, 1);
      got_err = err;
      @(negedge clk);
      chk("R13", "done one cycle", done, 0);
      repeat (6) @(negedge clk);
   endtask

   task automatic exp_wren(input int i);
      chk("R3", "wren kind", ev_kind[i], 0);
      chk("R3", "wren opcode", ev_opc[i], 8'h06);
      chk("R3", "wren modes", ev_am[i] * 4 + ev_dm[i], 0);
      chk("R3", "wel poll", ev_kind[i+1] * 1000 + ev_mask[i+1] * 16 + ev_match[i+1], 1000 + 32 + 2);
      chk("R3", "wel timeout", ev_tmo[i+1], 5000);
   endtask

   task automatic exp_busy(input int i, input longint tmo);
      chk("R5", "busy poll", ev_kind[i] * 1000 + ev_mask[i] * 16 + ev_match[i], 1000 + 16);
      chk("R5", "busy timeout", ev_tmo[i], tmo);
   endtask

   task automatic t_write(input logic [23:0] a0, input int len);
      int a, r, c, i, base;
      base = tot_bytes;
      run_req(2'd0, a0, 16'(len));
      a = a0; r = len; i = 0;
      while (r > 0) begin
         c = 256 - (a % 256);
         if (c > r) c = r;
         exp_wren(i);
         chk("R4", "prog opcode", ev_opc[i+2], 8'h32);
         chk("R4", "prog lanes", ev_am[i+2] * 4 + ev_dm[i+2], 10);
         chk("R2", "chunk address", ev_addr[i+2], a);
         chk(i == 0 ? "R1" : "R2", "chunk length", ev_nb[i+2], c);
         chk("R12", "bytes per chunk", ev_bytes[i+2], c);
         exp_busy(i+3, 5000);
         i += 4; a += c; r -= c;
      end
      chk("R2", "event count", n_ev, i);
      chk("R12", "total bytes", tot_bytes - base, len);
      chk("R8", "no error", got_err, 0);
      chk("R12", "din_ready idle", din_ready, 0);
   endtask

   task automatic t_sub_erase(input logic [23:0] a);
      run_req(2'd1, a, 16'd77);
      exp_wren(0);
      chk("R6", "sub opcode", ev_opc[2], 8'h20);
      chk("R6", "sub lanes", ev_am[2] * 4 + ev_dm[2], 4);
      chk("R6", "sub aligned addr", ev_addr[2], {a[23:12], 12'h000});
      chk("R6", "sub nbytes", ev_nb[2], 0);
      exp_busy(3, 400000);
      chk("R6", "event count", n_ev, 4);
      chk("R6", "no error", got_err, 0);
   endtask

   task automatic t_chip_erase();
      run_req(2'd2, 24'hABCDEF, 16'd0);
      exp_wren(0);
      chk("R7", "chip opcode", ev_opc[2], 8'hC7);
      chk("R7", "chip lanes", ev_am[2] * 4 + ev_dm[2], 0);
      exp_busy(3, 100000000);
      chk("R7", "event count", n_ev, 4);
   endtask

   task automatic t_zero_len();
      run_req(2'd0, 24'h000400, 16'd0);
      chk("R9", "done latency", got_wait, 0);
      chk("R9", "no error", got_err, 0);
      chk("R9", "no commands", n_ev, 0);
   endtask

   task automatic t_reserved();
      run_req(2'd3, 24'h000010, 16'd8);
      chk("R10", "done latency", got_wait, 0);
      chk("R10", "error flag", got_err, 1);
      chk("R10", "no commands", n_ev, 0);
   endtask

   task automatic t_poll_fail_mid_write();
      int base;
      base = tot_bytes;
      inj_err_ev = 5;
      run_req(2'd0, 24'h0000F0, 16'd300);
      inj_err_ev = -1;
      chk("R8", "error flag", got_err, 1);
      chk("R8", "stopped after failing poll", n_ev, 6);
      chk("R8", "bytes before failure", tot_bytes - base, 16);
   endtask

   task automatic t_cmd_fail_erase();
      inj_err_ev = 2;
      run_req(2'd1, 24'h003000, 16'd0);
      inj_err_ev = -1;
      chk("R8", "error flag", got_err, 1);
      chk("R8", "stopped after failing command", n_ev, 3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R13", "reset req_ready", req_ready, 1);
      chk("R13", "reset cmd_valid", cmd_valid, 0);
      chk("R13", "reset poll_valid", poll_valid, 0);
      chk("R13", "reset done", done, 0);
      chk("R12", "reset din_ready", din_ready, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_write(24'h000100, 16);
      t_write(24'h0000F0, 300);
      t_write(24'h000300, 512);
      t_write(24'h0003FF, 1);
      t_sub_erase(24'h012345);
      t_chip_erase();
      t_zero_len();
      t_reserved();
      t_poll_fail_mid_write();
      t_cmd_fail_erase();
      t_write(24'h0101FE, 3);
      chk("R12", "byte data unchanged", bad_data, 0);
      chk("R11", "command and poll overlap", overlap, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule